// File: doc/BRIEF.md
# Sticky Status and Error Aggregator

This block gathers thirteen condition strobes from the rest of a position-sensor chip into two 8-bit status registers. A host reads them over a simple strobe-and-address read port. A single configuration bit selects the view. In the live view the registers mirror the conditions as they are right now. In the latched view each bit captures any occurrence of its condition and holds it until it is cleared. A read of the owning register clears it, as do reads of two reserved addresses and the absolute-reset and soft-reset command strobes. Three bits are exempt from latching: startup, configuration-memory-missing and command-executing.

The same register contents feed two summary bits, one for errors and one for warnings. Per-message mask bits route each condition to a summary bit, where a 0 enables the message. The active serial protocol mode decides whether each summary bit appears in a frame and at which polarity. The error summary also drives an active-low error pin. Once the pin has asserted, it stays asserted for a programmable minimum time after the error has gone away.

Top module: `sense_status_hub`

## Requirements
- R1: A read strobe at address 0x76 returns register 0 on `rd_data_o` one cycle later, with bits 7:5 reading 0. Its bits are: bit 4 startup, bit 3 clipping on the secondary track, bit 2 low level on the secondary track, bit 1 clipping on the main track, bit 0 low level on the main track. Address 0x77 returns register 1. Its bits are: bit 7 RAM checksum error, bit 6 configuration memory missing, bit 5 multiturn communication error, bit 4 multiturn consistency error, bit 3 period-counter consistency error, bit 2 quadrature-converter overspeed, bit 1 internal-converter overspeed, bit 0 command executing. A read of any other address returns 0. `rd_data_o` holds its value in every cycle without a strobe. A 1 means the condition is true.
- R2: When `cfg_sticky_i` is 0, a read returns the condition inputs as they are in the strobe cycle.
- R3: When `cfg_sticky_i` is 1, a latchable bit reads 1 if its condition was high in any cycle since the bit was last cleared, including the strobe cycle itself.
- R4: In latched mode, a read of a status register clears that register's latched bits after returning the value from before the clear. A condition that is high in the clearing cycle leaves its bit set. A read of one register leaves the other register's latched bits intact.
- R5: In latched mode, a read of address 0x3D or 0x3E clears the latched bits of both registers, and so does `abs_rst_cmd_i` or `soft_rst_cmd_i`. Reads of 0x3D and 0x3E return 0.
- R6: Register 0 bit 4 and register 1 bits 6 and 0 always show the live condition, in either mode.
- R7: The error summary is the OR of the enabled messages, taken from the register contents as currently visible. The enables are `cfg_mask_i` bits that are 0: bit 7 enables both multiturn errors, bit 6 the period-counter error, bit 5 the four signal-level conditions, bit 4 configuration memory missing, bit 3 the checksum error, and bit 2 command executing.
- R8: The warning summary is built the same way. `cfg_mask_i` bit 1 enables either overspeed condition, and bit 0 enables the four signal-level conditions.
- R9: `cfg_proto_i` sets the frame bits. Codes 0, 2, 6 and 7 carry neither bit. Codes 1 and 5 carry an active-low error and an active-low warning. Code 3 carries an active-low error only. Code 4 carries an active-high error only. An `*_on_o` flag is 1 when the protocol carries that bit. An absent bit drives 0 on its level output.
- R10: With `cfg_pin_en_i` at 1, `err_pin_n_o` goes low in the cycle after the error summary becomes 1. It stays low while the summary is 1, and for `cfg_hold_i`×1024 further cycles after the last cycle in which the summary was 1.
- R11: With `cfg_pin_en_i` at 0, `err_pin_n_o` is high from the next cycle on, and any pending hold time is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stat0_raw_i | input | 5 | Condition strobes for register 0, in register bit order |
| stat1_raw_i | input | 8 | Condition strobes for register 1, in register bit order |
| rd_stb_i | input | 1 | Register read strobe |
| rd_addr_i | input | 8 | Read address |
| rd_data_o | output | 8 | Registered read data |
| abs_rst_cmd_i | input | 1 | Absolute-reset command strobe |
| soft_rst_cmd_i | input | 1 | Soft-reset command strobe |
| cfg_sticky_i | input | 1 | 0 selects the live view, 1 the latched view |
| cfg_mask_i | input | 8 | Message disables for the summary bits, 1 = disabled |
| cfg_proto_i | input | 3 | Serial protocol mode code |
| cfg_pin_en_i | input | 1 | Error pin enable |
| cfg_hold_i | input | 4 | Minimum pin time in units of 1024 cycles |
| err_bit_o | output | 1 | Error bit level for the frame |
| err_bit_on_o | output | 1 | Protocol carries the error bit |
| warn_bit_o | output | 1 | Warning bit level for the frame |
| warn_bit_on_o | output | 1 | Protocol carries the warning bit |
| err_pin_n_o | output | 1 | Active-low error pin |

## Verification
Some properties are checked on every cycle. The read data stays stable between strobes and unknown addresses read zero. In the live view, and for the three exempt bits, a read returns exactly the condition inputs. Silent protocol modes emit no bits, and the low-error mode inverts the summary. The pin asserts one cycle after an error and releases when disabled. Other behaviour needs the bench's per-cycle reference model. That covers whether a latched bit survives idle cycles, which events clear which register, how a condition racing a clearing read resolves, the full mask routing, and the exact length of the hold window.

// File: rtl/senshub_pkg.sv
package senshub_pkg;

  localparam int unsigned REG_W  = 8;
  localparam int unsigned S0_W   = 5;
  localparam int unsigned S1_W   = 8;

  // register 0 bit positions
  localparam int unsigned S0_LOW_MAIN  = 0;
  localparam int unsigned S0_CLIP_MAIN = 1;
  localparam int unsigned S0_LOW_SEC   = 2;
  localparam int unsigned S0_CLIP_SEC  = 3;
  localparam int unsigned S0_STARTUP   = 4;

  // register 1 bit positions
  localparam int unsigned S1_CMD_BUSY  = 0;
  localparam int unsigned S1_OVS_CONV  = 1;
  localparam int unsigned S1_OVS_QUAD  = 2;
  localparam int unsigned S1_PER_CONS  = 3;
  localparam int unsigned S1_MT_CONS   = 4;
  localparam int unsigned S1_MT_COMM   = 5;
  localparam int unsigned S1_NO_CFG    = 6;
  localparam int unsigned S1_RAM_CRC   = 7;

  // bits exempt from latching
  localparam logic [S0_W-1:0] LIVE0_DEF = S0_W'(1) << S0_STARTUP;
  localparam logic [S1_W-1:0] LIVE1_DEF = (S1_W'(1) << S1_NO_CFG) | (S1_W'(1) << S1_CMD_BUSY);

  // message disable bit positions
  localparam int unsigned MK_WARN_SIG = 0;
  localparam int unsigned MK_WARN_OVS = 1;
  localparam int unsigned MK_ERR_BUSY = 2;
  localparam int unsigned MK_ERR_CRC  = 3;
  localparam int unsigned MK_ERR_CFG  = 4;
  localparam int unsigned MK_ERR_SIG  = 5;
  localparam int unsigned MK_ERR_PER  = 6;
  localparam int unsigned MK_ERR_MT   = 7;

  typedef enum logic [2:0] {
    PROTO_SPI     = 3'd0,
    PROTO_BISS    = 3'd1,
    PROTO_SSI     = 3'd2,
    PROTO_SSI_ELO = 3'd3,
    PROTO_SSI_EHI = 3'd4,
    PROTO_XSSI    = 3'd5
  } proto_e;

  typedef struct packed {
    logic err_on;
    logic err_low;
    logic warn_on;
    logic warn_low;
  } frame_pol_t;

  function automatic frame_pol_t decode_proto(logic [2:0] code);
    frame_pol_t p;
    p = '0;
    case (code)
      PROTO_BISS, PROTO_XSSI: begin
        p.err_on = 1'b1; p.err_low = 1'b1; p.warn_on = 1'b1; p.warn_low = 1'b1;
      end
      PROTO_SSI_ELO: begin
        p.err_on = 1'b1; p.err_low = 1'b1;
      end
      PROTO_SSI_EHI: begin
        p.err_on = 1'b1;
      end
      default: p = '0;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/status_bank.sv
module status_bank #(
  parameter int unsigned     W         = 8,
  parameter logic [W-1:0]    LIVE_MASK = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sticky_i,
  input  logic [W-1:0] raw_i,
  input  logic         clr_i,
  output logic [W-1:0] disp_o
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (LIVE_MASK[i]) begin : g_live
      assign disp_o[i] = raw_i[i];
    end else begin : g_acc
      logic hold_q;
      logic hold_d;
      logic hold_en;

      always_comb begin
        hold_en = 1'b1;
        if (sticky_i) begin
          hold_d = raw_i[i] | (hold_q & ~clr_i);
        end else begin
          hold_d = 1'b0;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          hold_q <= 1'b0;
        end else if (hold_en) begin
          hold_q <= hold_d;
        end
      end

      assign disp_o[i] = sticky_i ? (hold_q | raw_i[i]) : raw_i[i];
    end
  end

endmodule

// File: rtl/summary_route.sv
module summary_route
  import senshub_pkg::*;
(
  input  logic [S0_W-1:0]  disp0_i,
  input  logic [S1_W-1:0]  disp1_i,
  input  logic [REG_W-1:0] mask_i,
  input  logic [2:0]       proto_i,
  output logic             err_sum_o,
  output logic             warn_sum_o,
  output logic             err_bit_o,
  output logic             err_on_o,
  output logic             warn_bit_o,
  output logic             warn_on_o
);

  logic       sig_any;
  logic       mt_any;
  logic       ovs_any;
  logic [5:0] err_src;
  logic [1:0] warn_src;
  frame_pol_t pol;

  always_comb begin
    sig_any = disp0_i[S0_LOW_MAIN] | disp0_i[S0_CLIP_MAIN]
            | disp0_i[S0_LOW_SEC]  | disp0_i[S0_CLIP_SEC];
    mt_any  = disp1_i[S1_MT_COMM] | disp1_i[S1_MT_CONS];
    ovs_any = disp1_i[S1_OVS_QUAD] | disp1_i[S1_OVS_CONV];

    err_src[0] = ~mask_i[MK_ERR_MT]   & mt_any;
    err_src[1] = ~mask_i[MK_ERR_PER]  & disp1_i[S1_PER_CONS];
    err_src[2] = ~mask_i[MK_ERR_SIG]  & sig_any;
    err_src[3] = ~mask_i[MK_ERR_CFG]  & disp1_i[S1_NO_CFG];
    err_src[4] = ~mask_i[MK_ERR_CRC]  & disp1_i[S1_RAM_CRC];
    err_src[5] = ~mask_i[MK_ERR_BUSY] & disp1_i[S1_CMD_BUSY];

    warn_src[0] = ~mask_i[MK_WARN_OVS] & ovs_any;
    warn_src[1] = ~mask_i[MK_WARN_SIG] & sig_any;

    err_sum_o  = |err_src;
    warn_sum_o = |warn_src;
  end

  always_comb begin
    pol        = decode_proto(proto_i);
    err_on_o   = pol.err_on;
    warn_on_o  = pol.warn_on;
    err_bit_o  = pol.err_on  ? (err_sum_o  ^ pol.err_low)  : 1'b0;
    warn_bit_o = pol.warn_on ? (warn_sum_o ^ pol.warn_low) : 1'b0;
  end

endmodule

// File: rtl/pin_stretch.sv
module pin_stretch #(
  parameter int unsigned HOLD_W    = 4,
  parameter int unsigned UNIT_LOG2 = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic              err_i,
  input  logic [HOLD_W-1:0] hold_i,
  output logic              pin_n_o
);

  localparam int unsigned CNT_W = HOLD_W + UNIT_LOG2;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             pin_q, pin_d;
  logic             cnt_live;

  assign cnt_live = (cnt_q != '0);

  always_comb begin
    if (!en_i) begin
      cnt_d = '0;
      pin_d = 1'b0;
    end else begin
      pin_d = err_i | cnt_live;
      if (err_i) begin
        cnt_d = {hold_i, {UNIT_LOG2{1'b0}}};
      end else if (cnt_live) begin
        cnt_d = cnt_q - CNT_W'(1);
      end else begin
        cnt_d = cnt_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      pin_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      pin_q <= pin_d;
    end
  end

  assign pin_n_o = ~pin_q;

endmodule

// File: rtl/sense_status_hub.sv
module sense_status_hub
  import senshub_pkg::*;
#(
  parameter int unsigned        ADDR_W     = 8,
  parameter logic [ADDR_W-1:0]  ADDR_STAT0 = 8'h76,
  parameter logic [ADDR_W-1:0]  ADDR_STAT1 = 8'h77,
  parameter logic [ADDR_W-1:0]  ADDR_CLR_A = 8'h3D,
  parameter logic [ADDR_W-1:0]  ADDR_CLR_B = 8'h3E,
  parameter int unsigned        HOLD_W     = 4,
  parameter int unsigned        UNIT_LOG2  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [S0_W-1:0]   stat0_raw_i,
  input  logic [S1_W-1:0]   stat1_raw_i,
  input  logic              rd_stb_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [REG_W-1:0]  rd_data_o,
  input  logic              abs_rst_cmd_i,
  input  logic              soft_rst_cmd_i,
  input  logic              cfg_sticky_i,
  input  logic [REG_W-1:0]  cfg_mask_i,
  input  logic [2:0]        cfg_proto_i,
  input  logic              cfg_pin_en_i,
  input  logic [HOLD_W-1:0] cfg_hold_i,
  output logic              err_bit_o,
  output logic              err_bit_on_o,
  output logic              warn_bit_o,
  output logic              warn_bit_on_o,
  output logic              err_pin_n_o
);

  logic              hit0, hit1, hit_rsv, cmd_clr;
  logic              clr0, clr1;
  logic [S0_W-1:0]   disp0;
  logic [S1_W-1:0]   disp1;
  logic [REG_W-1:0]  rd_data_q, rd_data_d;
  logic              rd_en;
  logic              err_sum, warn_sum;

  // read address decode and clear sources
  always_comb begin
    hit0    = rd_stb_i & (rd_addr_i == ADDR_STAT0);
    hit1    = rd_stb_i & (rd_addr_i == ADDR_STAT1);
    hit_rsv = rd_stb_i & ((rd_addr_i == ADDR_CLR_A) | (rd_addr_i == ADDR_CLR_B));
    cmd_clr = abs_rst_cmd_i | soft_rst_cmd_i;
    clr0    = hit0 | hit_rsv | cmd_clr;
    clr1    = hit1 | hit_rsv | cmd_clr;
  end

  status_bank #(.W(S0_W), .LIVE_MASK(LIVE0_DEF)) i_bank0 (
    .clk      (clk),
    .rst_n    (rst_n),
    .sticky_i (cfg_sticky_i),
    .raw_i    (stat0_raw_i),
    .clr_i    (clr0),
    .disp_o   (disp0)
  );

  status_bank #(.W(S1_W), .LIVE_MASK(LIVE1_DEF)) i_bank1 (
    .clk      (clk),
    .rst_n    (rst_n),
    .sticky_i (cfg_sticky_i),
    .raw_i    (stat1_raw_i),
    .clr_i    (clr1),
    .disp_o   (disp1)
  );

  // read data register
  always_comb begin
    rd_en = rd_stb_i;
    if (hit0) begin
      rd_data_d = REG_W'(disp0);
    end else if (hit1) begin
      rd_data_d = REG_W'(disp1);
    end else begin
      rd_data_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data_q <= '0;
    end else if (rd_en) begin
      rd_data_q <= rd_data_d;
    end
  end

  assign rd_data_o = rd_data_q;

  summary_route i_route (
    .disp0_i    (disp0),
    .disp1_i    (disp1),
    .mask_i     (cfg_mask_i),
    .proto_i    (cfg_proto_i),
    .err_sum_o  (err_sum),
    .warn_sum_o (warn_sum),
    .err_bit_o  (err_bit_o),
    .err_on_o   (err_bit_on_o),
    .warn_bit_o (warn_bit_o),
    .warn_on_o  (warn_bit_on_o)
  );

  pin_stretch #(.HOLD_W(HOLD_W), .UNIT_LOG2(UNIT_LOG2)) i_pin (
    .clk     (clk),
    .rst_n   (rst_n),
    .en_i    (cfg_pin_en_i),
    .err_i   (err_sum),
    .hold_i  (cfg_hold_i),
    .pin_n_o (err_pin_n_o)
  );

endmodule

// File: rtl/sense_status_hub_chk.sv
module sense_status_hub_chk
  import senshub_pkg::*;
#(
  parameter int unsigned       ADDR_W     = 8,
  parameter logic [ADDR_W-1:0] ADDR_STAT0 = 8'h76,
  parameter logic [ADDR_W-1:0] ADDR_STAT1 = 8'h77
) (
  input logic              clk,
  input logic              rst_n,
  input logic [S0_W-1:0]   stat0_raw_i,
  input logic [S1_W-1:0]   stat1_raw_i,
  input logic              rd_stb_i,
  input logic [ADDR_W-1:0] rd_addr_i,
  input logic [REG_W-1:0]  rd_data_o,
  input logic              cfg_sticky_i,
  input logic [2:0]        cfg_proto_i,
  input logic              cfg_pin_en_i,
  input logic              err_bit_o,
  input logic              err_bit_on_o,
  input logic              warn_bit_o,
  input logic              warn_bit_on_o,
  input logic              err_pin_n_o,
  input logic              err_sum
);

  p_other_addr_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb_i && rd_addr_i != ADDR_STAT0 && rd_addr_i != ADDR_STAT1 |=> rd_data_o == '0);

  p_reg0_pad_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb_i && rd_addr_i == ADDR_STAT0 |=> rd_data_o[7:5] == 3'b000);

  p_rd_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb_i |=> $stable(rd_data_o));

  p_live_view_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_sticky_i && rd_stb_i && rd_addr_i == ADDR_STAT1 |=> rd_data_o == $past(stat1_raw_i));

  p_seen_on_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_sticky_i && rd_stb_i && rd_addr_i == ADDR_STAT0 && stat0_raw_i[S0_LOW_MAIN]
    |=> rd_data_o[S0_LOW_MAIN]);

  p_startup_live_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb_i && rd_addr_i == ADDR_STAT0 |=> rd_data_o[S0_STARTUP] == $past(stat0_raw_i[S0_STARTUP]));

  p_exempt_live_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb_i && rd_addr_i == ADDR_STAT1
    |=> rd_data_o[S1_NO_CFG] == $past(stat1_raw_i[S1_NO_CFG])
        && rd_data_o[S1_CMD_BUSY] == $past(stat1_raw_i[S1_CMD_BUSY]));

  p_quiet_frame_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_proto_i == 3'd0 || cfg_proto_i == 3'd2 || cfg_proto_i >= 3'd6)
    |-> !err_bit_on_o && !warn_bit_on_o && !err_bit_o && !warn_bit_o);

  p_low_err_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_proto_i == 3'd3 |-> err_bit_on_o && !warn_bit_on_o && (err_bit_o == !err_sum));

  p_pin_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_pin_en_i && err_sum |=> !err_pin_n_o);

  p_pin_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_pin_en_i |=> err_pin_n_o);

endmodule

bind sense_status_hub sense_status_hub_chk #(
  .ADDR_W     (ADDR_W),
  .ADDR_STAT0 (ADDR_STAT0),
  .ADDR_STAT1 (ADDR_STAT1)
) i_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .stat0_raw_i   (stat0_raw_i),
  .stat1_raw_i   (stat1_raw_i),
  .rd_stb_i      (rd_stb_i),
  .rd_addr_i     (rd_addr_i),
  .rd_data_o     (rd_data_o),
  .cfg_sticky_i  (cfg_sticky_i),
  .cfg_proto_i   (cfg_proto_i),
  .cfg_pin_en_i  (cfg_pin_en_i),
  .err_bit_o     (err_bit_o),
  .err_bit_on_o  (err_bit_on_o),
  .warn_bit_o    (warn_bit_o),
  .warn_bit_on_o (warn_bit_on_o),
  .err_pin_n_o   (err_pin_n_o),
  .err_sum       (err_sum)
);

// File: tb/test_sense_status_hub.sv
`timescale 1ns/1ps
module test_sense_status_hub;

  logic       clk;
  logic       rst_n;
  logic [4:0] c0;
  logic [7:0] c1;
  logic       rd;
  logic [7:0] addr;
  logic [7:0] rd_data;
  logic       abs_cmd, soft_cmd;
  logic       sticky;
  logic [7:0] mask;
  logic [2:0] proto;
  logic       pin_en;
  logic [3:0] hold;
  logic       eb, eb_on, wb, wb_on, pin_n;

  int    checks = 0;
  int    fails  = 0;
  bit    done   = 0;
  string tag    = "R1";

  // behavioural reference state
  logic [4:0] m_st0;
  logic [7:0] m_st1;
  logic [7:0] m_rd;
  logic       m_pin;
  int         m_cnt;

  sense_status_hub i_sense_status_hub (
    .clk(clk), .rst_n(rst_n),
    .stat0_raw_i(c0), .stat1_raw_i(c1),
    .rd_stb_i(rd), .rd_addr_i(addr), .rd_data_o(rd_data),
    .abs_rst_cmd_i(abs_cmd), .soft_rst_cmd_i(soft_cmd),
    .cfg_sticky_i(sticky), .cfg_mask_i(mask), .cfg_proto_i(proto),
    .cfg_pin_en_i(pin_en), .cfg_hold_i(hold),
    .err_bit_o(eb), .err_bit_on_o(eb_on), .warn_bit_o(wb), .warn_bit_on_o(wb_on),
    .err_pin_n_o(pin_n)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // visible contents: startup (r0 b4), no-config (r1 b6), busy (r1 b0) never latch (R6)
  function automatic logic [4:0] vis0();
    return sticky ? (((m_st0 | c0) & 5'h0F) | (c0 & 5'h10)) : c0;
  endfunction
  function automatic logic [7:0] vis1();
    return sticky ? (((m_st1 | c1) & 8'hBE) | (c1 & 8'h41)) : c1;
  endfunction

  function automatic logic err_of(logic [4:0] d0, logic [7:0] d1);
    logic e;
    e = 0;
    if (!mask[7] && (d1[5] || d1[4])) e = 1;   // R7 multiturn
    if (!mask[6] && d1[3])            e = 1;   // R7 period counter
    if (!mask[5] && d0[3:0] != 0)     e = 1;   // R7 signal level
    if (!mask[4] && d1[6])            e = 1;   // R7 config memory
    if (!mask[3] && d1[7])            e = 1;   // R7 checksum
    if (!mask[2] && d1[0])            e = 1;   // R7 busy
    return e;
  endfunction
  function automatic logic warn_of(logic [4:0] d0, logic [7:0] d1);
    return (!mask[1] && (d1[2] || d1[1])) || (!mask[0] && d0[3:0] != 0); // R8
  endfunction

  task automatic chk(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare();
    logic e, w, xe_on, xe_low, xw_on, xw_low;
    e = err_of(vis0(), vis1());
    w = warn_of(vis0(), vis1());
    xe_on = 0; xe_low = 0; xw_on = 0; xw_low = 0;
    case (proto)                                  // R9
      3'd1, 3'd5: begin xe_on = 1; xe_low = 1; xw_on = 1; xw_low = 1; end
      3'd3:       begin xe_on = 1; xe_low = 1; end
      3'd4:       begin xe_on = 1; end
      default: ;
    endcase
    chk("rd_data",  rd_data, m_rd);
    chk("err_on",   eb_on, xe_on);
    chk("warn_on",  wb_on, xw_on);
    chk("err_bit",  eb, xe_on ? (xe_low ? !e : e) : 0);
    chk("warn_bit", wb, xw_on ? (xw_low ? !w : w) : 0);
    chk("err_pin_n", pin_n, !m_pin);
  endtask

  // one clock: compare at negedge+1, advance model at posedge, return at negedge
  task automatic cyc();
    logic [4:0] d0;
    logic [7:0] d1;
    logic e, clr_all, clr0, clr1;
    #1;
    compare();
    @(posedge clk);
    d0 = vis0(); d1 = vis1();
    e  = err_of(d0, d1);
    if (rd) m_rd = (addr == 8'h76) ? {3'b000, d0} : (addr == 8'h77) ? d1 : 8'h00;
    if (!pin_en) begin m_pin = 0; m_cnt = 0; end
    else begin
      m_pin = e || (m_cnt != 0);
      m_cnt = e ? int'(hold) * 1024 : (m_cnt > 0 ? m_cnt - 1 : 0);
    end
    clr_all = (rd && (addr == 8'h3D || addr == 8'h3E)) || abs_cmd || soft_cmd;
    clr0 = clr_all || (rd && addr == 8'h76);
    clr1 = clr_all || (rd && addr == 8'h77);
    if (sticky) begin
      m_st0 = (c0 | (clr0 ? 5'h00 : m_st0)) & 5'h0F;
      m_st1 = (c1 | (clr1 ? 8'h00 : m_st1)) & 8'hBE;
    end else begin
      m_st0 = 0; m_st1 = 0;
    end
    @(negedge clk);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic do_read(logic [7:0] a);
    rd = 1; addr = a; cyc(); rd = 0; addr = 8'h00; cyc();
  endtask

  task automatic set_cond(int k, logic v);
    if (k < 5) c0[k] = v; else c1[k-5] = v;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R1 watchdog: actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    rst_n = 0; c0 = 0; c1 = 0; rd = 0; addr = 0; abs_cmd = 0; soft_cmd = 0;
    sticky = 0; mask = 8'hFF; proto = 3'd0; pin_en = 0; hold = 0;
    m_st0 = 0; m_st1 = 0; m_rd = 0; m_pin = 0; m_cnt = 0;
    repeat (3) @(negedge clk);
    tag = "R1";                         // reset state
    #1; compare(); @(negedge clk);
    rst_n = 1;
    cyc();

    // R1 / R2: layout and live view
    tag = "R1";
    c0 = 5'h15; c1 = 8'hA5;
    do_read(8'h76); do_read(8'h77); do_read(8'h10);
    tag = "R2";
    c0 = 5'h0A; c1 = 8'h5A; do_read(8'h77); do_read(8'h76);
    c0 = 0; c1 = 0; do_read(8'h77);

    // R3: latching of a one-cycle pulse
    tag = "R3";
    sticky = 1; cyc();
    c1 = 8'h80; c0 = 5'h02; cyc(); c1 = 0; c0 = 0; idle(3);
    do_read(8'h77);
    // R4: read clears own register only, pre-clear value returned
    tag = "R4";
    do_read(8'h77);
    do_read(8'h76); do_read(8'h76);
    c1 = 8'h08; cyc(); c1 = 8'h00;
    c0 = 5'h01; rd = 1; addr = 8'h76; cyc(); rd = 0; c0 = 0; cyc();
    do_read(8'h76); do_read(8'h77); do_read(8'h77);

    // R5: reserved addresses and commands clear both
    tag = "R5";
    for (int j = 0; j < 4; j++) begin
      c0 = 5'h0C; c1 = 8'h36; cyc(); c0 = 0; c1 = 0; cyc();
      case (j)
        0: begin rd = 1; addr = 8'h3D; end
        1: begin rd = 1; addr = 8'h3E; end
        2: abs_cmd = 1;
        default: soft_cmd = 1;
      endcase
      cyc(); rd = 0; addr = 0; abs_cmd = 0; soft_cmd = 0; cyc();
      do_read(8'h76); do_read(8'h77);
    end

    // R6: exempt bits never latch
    tag = "R6";
    c0 = 5'h10; c1 = 8'h41; cyc(); c0 = 0; c1 = 0; idle(2);
    do_read(8'h76); do_read(8'h77);

    // R7: each error enable against every condition
    tag = "R7";
    proto = 3'd4;
    for (int m = 2; m < 8; m++) begin
      mask = ~(8'h01 << m);
      for (int k = 0; k < 13; k++) begin
        set_cond(k, 1); cyc(); set_cond(k, 0); abs_cmd = 1; cyc(); abs_cmd = 0;
      end
    end
    // R8: warning enables
    tag = "R8";
    proto = 3'd1; sticky = 0;
    for (int m = 0; m < 2; m++) begin
      mask = ~(8'h01 << m);
      for (int k = 0; k < 13; k++) begin set_cond(k, 1); cyc(); set_cond(k, 0); cyc(); end
    end

    // R9: every protocol code, error and warning on and off
    tag = "R9";
    mask = 8'h00;
    for (int p = 0; p < 8; p++) begin
      proto = 3'(p);
      c0 = 0; c1 = 0; cyc();
      c1 = 8'h02; cyc();
      c1 = 8'h80; cyc();
      c0 = 5'h01; c1 = 0; cyc();
    end
    c0 = 0; c1 = 0;

    // R10: minimum pin time
    tag = "R10";
    mask = 8'h00; pin_en = 1; hold = 4'd1; proto = 3'd1;
    c1 = 8'h80; cyc(); c1 = 0; idle(1030);
    hold = 4'd0; c1 = 8'h80; idle(3); c1 = 0; idle(4);
    hold = 4'd2; c1 = 8'h08; idle(5); c1 = 0; idle(2060);
    // R11: disabling drops the pin and the pending hold
    tag = "R11";
    hold = 4'd1; c1 = 8'h80; cyc(); c1 = 0; idle(10);
    pin_en = 0; idle(5); pin_en = 1; idle(5);
    pin_en = 0; c1 = 8'h80; idle(3); c1 = 0; pin_en = 1; idle(3);

    // R4: mixed traffic with reads racing conditions
    tag = "R4";
    hold = 4'd0;
    for (int i = 0; i < 3000; i++) begin
      c0 = ($urandom_range(0, 7) == 0) ? 5'($urandom) : 5'h00;
      c1 = ($urandom_range(0, 7) == 0) ? 8'($urandom) : 8'h00;
      rd = ($urandom_range(0, 3) == 0);
      case ($urandom_range(0, 4))
        0: addr = 8'h76; 1: addr = 8'h77; 2: addr = 8'h3D; 3: addr = 8'h3E;
        default: addr = 8'($urandom);
      endcase
      abs_cmd  = ($urandom_range(0, 31) == 0);
      soft_cmd = ($urandom_range(0, 31) == 0);
      if ($urandom_range(0, 63) == 0) begin
        sticky = !sticky; mask = 8'($urandom); proto = 3'($urandom);
      end
      cyc();
    end
    rd = 0; abs_cmd = 0; soft_cmd = 0; c0 = 0; c1 = 0; cyc();

    done = 1;
    finish_run();
  end

endmodule